// File: doc/BRIEF.md
# Instruction Prefix Tracking Unit

This block sits between an instruction decoder and the register file and flag logic of a 16-bit CPU core. It keeps track of two one-byte prefix codes. The bank-zero prefix makes the register-bank accesses of the next instruction use bank zero. The no-flag prefix stops the next instruction from writing the condition code register (CCR).

The decoder presents each completed instruction with a strobe and a 3-bit class code. Along with it come the current bank pointer, the register index within the bank, the CCR update request that the datapath computed, and the current stack-select flag. The block then returns the effective register byte address and a gated CCR write enable. It also returns a stack select that forces the system stack for interrupt return.

Prefixes are held in one pending bit each, and both can be pending together. Flag-changing and mask-setting instructions run as written and leave a pending prefix in place for the instruction after them. Any interrupt entry discards both prefixes, so a string instruction that resumes after an interrupt runs without them.

Top module: `pfx_track`

## Requirements
- R1: With no bank-zero prefix in force, `reg_addr` equals 0x180 + 16 × `bank_ptr` + `reg_idx`, combinationally from the same-cycle inputs.
- R2: After a bank-zero prefix strobe (class 1), the next valid plain instruction (class 0) gets `reg_addr` = 0x180 + `reg_idx`, whatever the value of `bank_ptr`.
- R3: After a no-flag prefix strobe (class 2), the next valid plain instruction gives `ccr_we` = 0 even when `ccr_req` = 1. The prefix stays pending across cycles with `dec_valid` = 0.
- R4: A flag-changing instruction (class 3) that follows a prefix writes CCR as requested and uses its normal bank address. The prefix stays pending for the next instruction.
- R5: A mask-setting instruction (class 4) behaves like class 3: it executes normally and carries the pending prefix over to the following instruction.
- R6: Software interrupt (class 5), interrupt return (class 6) and context jump (class 7) write CCR whenever `ccr_req` = 1, even under the no-flag prefix. Each of them consumes any pending prefix.
- R7: A valid interrupt return (class 6) drives `sys_stack` = 1 whatever prefix is pending. Otherwise `sys_stack` follows `stack_flag`.
- R8: A cycle with `irq_entry` = 1 clears both pending prefixes, so the next plain instruction uses its normal bank and writes CCR.
- R9: Both prefixes can be pending at once. The next plain instruction then gets bank zero and no CCR write.
- R10: A pending prefix is consumed by the first valid plain instruction. The plain instruction after that gets its normal address and CCR write.
- R11: Reset clears both prefixes. `ccr_we` is 0 whenever `dec_valid` = 0, and a prefix strobe (class 1 or 2) never writes CCR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decoded instruction strobe |
| dec_class | input | 3 | Instruction class: 0 plain, 1 bank-zero prefix, 2 no-flag prefix, 3 flag op, 4 mask set, 5 software interrupt, 6 interrupt return, 7 context jump |
| bank_ptr | input | PTR_W (5) | Current register bank pointer |
| reg_idx | input | log2(BANK_BYTES) (4) | Byte index inside the bank |
| irq_entry | input | 1 | Hardware interrupt being taken this cycle |
| ccr_req | input | 1 | Datapath wants to update CCR |
| stack_flag | input | 1 | Current stack select (1 = system stack) |
| reg_addr | output | ADDR_W (24) | Effective register byte address |
| ccr_we | output | 1 | Gated CCR write enable |
| sys_stack | output | 1 | Stack select used by this instruction |

## Verification
The bench sends sequences of prefixes followed by a flag op or a mask-set instruction. A design that consumed the prefix too early would give a normal bank address or a CCR write on the instruction after the carry-over. It also checks that interrupt-class instructions write CCR under the no-flag prefix; a design that missed this would drop the flag update of an interrupt or a return. An interrupt entry taken with both prefixes pending checks the invalidation path: a design that kept stale prefixes would send the resumed instruction to bank zero. Idle cycles between a prefix and its consumer would show a design that consumes on cycles without a strobe.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

   typedef enum logic [2:0] {
      IC_PLAIN      = 3'd0,
      IC_PFX_BANK0  = 3'd1,
      IC_PFX_NOFLAG = 3'd2,
      IC_FLAGOP     = 3'd3,
      IC_MASKSET    = 3'd4,
      IC_SWINT      = 3'd5,
      IC_IRET       = 3'd6,
      IC_CTXJMP     = 3'd7
   } icls_e;

   // number of tracked prefix kinds; index 0 = bank zero, 1 = no flag
   localparam int NUM_PFX = 2;

   function automatic logic f_is_prefix(input icls_e c);
      return (c == IC_PFX_BANK0) || (c == IC_PFX_NOFLAG);
   endfunction

   // classes that leave a pending prefix untouched
   function automatic logic f_keeps_prefix(input icls_e c);
      return f_is_prefix(c) || (c == IC_FLAGOP) || (c == IC_MASKSET);
   endfunction

   // classes whose CCR update is never masked
   function automatic logic f_ccr_forced(input icls_e c);
      return (c == IC_SWINT) || (c == IC_IRET) || (c == IC_CTXJMP);
   endfunction

endpackage

// File: rtl/pfx_state.sv
module pfx_state
   import pfx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dec_valid,
   input  icls_e             icls,
   input  logic              irq_entry,
   output logic [NUM_PFX-1:0] pend
);

   for (genvar g = 0; g < NUM_PFX; g++) begin : g_pfx
      localparam icls_e SET_CODE = (g == 0) ? IC_PFX_BANK0 : IC_PFX_NOFLAG;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend[g] <= 1'b0;
         end else if (irq_entry) begin
            pend[g] <= 1'b0;
         end else if (dec_valid) begin
            if (icls == SET_CODE) begin
               pend[g] <= 1'b1;
            end else if (!f_keeps_prefix(icls)) begin
               pend[g] <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/pfx_bank_map.sv
module pfx_bank_map #(
   parameter int ADDR_W     = 24,
   parameter int PTR_W      = 5,
   parameter int BANK_BYTES = 16,
   parameter int BANK_BASE  = 'h180
) (
   input  logic                          force0,
   input  logic [PTR_W-1:0]              ptr,
   input  logic [$clog2(BANK_BYTES)-1:0] idx,
   output logic [ADDR_W-1:0]             addr
);

   localparam int IDX_W = $clog2(BANK_BYTES);
   localparam int SPAN  = BANK_BYTES << PTR_W;

   if ((1 << IDX_W) != BANK_BYTES) begin : g_bad_bytes
      $error("BANK_BYTES must be a power of two");
   end
   if (PTR_W + IDX_W > ADDR_W) begin : g_bad_width
      $error("bank space does not fit in ADDR_W");
   end

   logic [PTR_W-1:0]  p_eff;
   logic [ADDR_W-1:0] off;

   assign p_eff = force0 ? '0 : ptr;
   assign off   = ADDR_W'({p_eff, idx});

   if ((BANK_BASE % SPAN) == 0) begin : g_aligned
      assign addr = ADDR_W'(BANK_BASE) | off;
   end else begin : g_offset
      assign addr = ADDR_W'(BANK_BASE) + off;
   end

endmodule

// File: rtl/pfx_ccr_gate.sv
module pfx_ccr_gate
   import pfx_pkg::*;
(
   input  logic  dec_valid,
   input  icls_e icls,
   input  logic  ccr_req,
   input  logic  noflag_pend,
   output logic  ccr_we
);

   logic masked;

   always_comb begin
      masked = noflag_pend && !f_keeps_prefix(icls) && !f_ccr_forced(icls);
      ccr_we = dec_valid && ccr_req && !f_is_prefix(icls) && !masked;
   end

endmodule

// File: rtl/pfx_track.sv
module pfx_track
   import pfx_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int PTR_W      = 5,
   parameter int BANK_BYTES = 16,
   parameter int BANK_BASE  = 'h180
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          dec_valid,
   input  logic [2:0]                    dec_class,
   input  logic [PTR_W-1:0]              bank_ptr,
   input  logic [$clog2(BANK_BYTES)-1:0] reg_idx,
   input  logic                          irq_entry,
   input  logic                          ccr_req,
   input  logic                          stack_flag,
   output logic [ADDR_W-1:0]             reg_addr,
   output logic                          ccr_we,
   output logic                          sys_stack
);

   icls_e              icls;
   logic [NUM_PFX-1:0] pend;
   logic               force0;

   assign icls   = icls_e'(dec_class);
   assign force0 = pend[0] && (icls == IC_PLAIN);

   pfx_state u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .dec_valid (dec_valid),
      .icls      (icls),
      .irq_entry (irq_entry),
      .pend      (pend)
   );

   pfx_bank_map #(
      .ADDR_W     (ADDR_W),
      .PTR_W      (PTR_W),
      .BANK_BYTES (BANK_BYTES),
      .BANK_BASE  (BANK_BASE)
   ) u_map (
      .force0 (force0),
      .ptr    (bank_ptr),
      .idx    (reg_idx),
      .addr   (reg_addr)
   );

   pfx_ccr_gate u_gate (
      .dec_valid   (dec_valid),
      .icls        (icls),
      .ccr_req     (ccr_req),
      .noflag_pend (pend[1]),
      .ccr_we      (ccr_we)
   );

   assign sys_stack = stack_flag || (dec_valid && (icls == IC_IRET));

endmodule

// File: rtl/pfx_track_chk.sv
module pfx_track_chk #(
   parameter int ADDR_W     = 24,
   parameter int PTR_W      = 5,
   parameter int BANK_BYTES = 16,
   parameter int BANK_BASE  = 'h180
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          dec_valid,
   input logic [2:0]                    dec_class,
   input logic [PTR_W-1:0]              bank_ptr,
   input logic [$clog2(BANK_BYTES)-1:0] reg_idx,
   input logic                          irq_entry,
   input logic                          ccr_req,
   input logic [ADDR_W-1:0]             reg_addr,
   input logic                          ccr_we,
   input logic                          sys_stack
);

   logic              irq_q;
   logic              plain_q;
   logic [ADDR_W-1:0] norm_addr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q   <= 1'b0;
         plain_q <= 1'b0;
      end else begin
         irq_q   <= irq_entry;
         plain_q <= dec_valid && (dec_class == 3'd0) && !irq_entry;
      end
   end

   assign norm_addr = ADDR_W'(BANK_BASE) + ADDR_W'(bank_ptr) * ADDR_W'(BANK_BYTES)
                      + ADDR_W'(reg_idx);

   // R11
   prefix_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && (dec_class == 3'd1 || dec_class == 3'd2)) |-> !ccr_we);

   // R11
   we_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ccr_we |-> (dec_valid && ccr_req));

   // R6
   forced_ccr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && ccr_req && dec_class >= 3'd5) |-> ccr_we);

   // R7
   iret_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_class == 3'd6) |-> sys_stack);

   // R8
   irq_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && dec_valid && dec_class == 3'd0 && ccr_req) |-> ccr_we);

   // R8
   irq_clears_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && dec_class == 3'd0) |-> (reg_addr == norm_addr));

   // R10
   consumed_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (plain_q && dec_valid && dec_class == 3'd0 && ccr_req) |-> ccr_we);

endmodule

bind pfx_track pfx_track_chk #(
   .ADDR_W     (ADDR_W),
   .PTR_W      (PTR_W),
   .BANK_BYTES (BANK_BYTES),
   .BANK_BASE  (BANK_BASE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .dec_valid (dec_valid),
   .dec_class (dec_class),
   .bank_ptr  (bank_ptr),
   .reg_idx   (reg_idx),
   .irq_entry (irq_entry),
   .ccr_req   (ccr_req),
   .reg_addr  (reg_addr),
   .ccr_we    (ccr_we),
   .sys_stack (sys_stack)
);

// File: tb/sim_pfx_track.sv
module sim_pfx_track;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dec_valid = 1'b0;
   logic [2:0]  dec_class = 3'd0;
   logic [4:0]  bank_ptr = 5'd0;
   logic [3:0]  reg_idx = 4'd0;
   logic        irq_entry = 1'b0;
   logic        ccr_req = 1'b0;
   logic        stack_flag = 1'b0;
   logic [23:0] reg_addr;
   logic        ccr_we;
   logic        sys_stack;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pfx_track u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .dec_valid  (dec_valid),
      .dec_class  (dec_class),
      .bank_ptr   (bank_ptr),
      .reg_idx    (reg_idx),
      .irq_entry  (irq_entry),
      .ccr_req    (ccr_req),
      .stack_flag (stack_flag),
      .reg_addr   (reg_addr),
      .ccr_we     (ccr_we),
      .sys_stack  (sys_stack)
   );

   // row: tag | valid | class | ptr | idx | irq | req | sflag || we | addr | sys
   function automatic logic [45:0] row(int tag, int v, int c, int p, int i, int q,
                                       int r, int s, int we, int a, int sy);
      return {4'(tag), 1'(v), 3'(c), 5'(p), 4'(i), 1'(q), 1'(r), 1'(s),
              1'(we), 24'(a), 1'(sy)};
   endfunction

   localparam int NV = 34;
   localparam logic [45:0] VEC [NV] = '{
      row(1, 1,0, 3, 2,0,1,0, 1,'h1B2,0),  // R1 plain access
      row(7, 1,0,31,15,0,0,1, 0,'h37F,1),  // R7 stack follows flag, R1 top bank
      row(2, 1,1, 7, 0,0,1,0, 0,'h1F0,0),  // R2 bank-zero prefix
      row(2, 1,0, 7, 5,0,1,0, 1,'h185,0),  // R2 forced to bank zero
      row(10,1,0, 7, 5,0,1,0, 1,'h1F5,0),  // R10 consumed
      row(3, 1,2, 0, 0,0,1,0, 0,'h180,0),  // R3 no-flag prefix
      row(3, 1,0, 2, 1,0,1,0, 0,'h1A1,0),  // R3 write masked
      row(10,1,0, 2, 1,0,1,0, 1,'h1A1,0),  // R10 consumed
      row(4, 1,2, 0, 0,0,0,0, 0,'h180,0),  // R4
      row(4, 1,3, 4, 0,0,1,0, 1,'h1C0,0),  // R4 flag op runs normally
      row(4, 1,0, 4, 3,0,1,0, 0,'h1C3,0),  // R4 carried over
      row(5, 1,1, 9, 0,0,0,0, 0,'h210,0),  // R5
      row(5, 1,4, 9, 0,0,1,0, 1,'h210,0),  // R5 mask set runs normally
      row(5, 1,0, 9, 6,0,1,0, 1,'h186,0),  // R5 carried over
      row(6, 1,2, 0, 0,0,0,0, 0,'h180,0),  // R6
      row(6, 1,5, 1, 0,0,1,0, 1,'h190,0),  // R6 software interrupt writes
      row(6, 1,0, 1, 0,0,1,0, 1,'h190,0),  // R6 consumed
      row(6, 1,2, 0, 0,0,0,0, 0,'h180,0),  // R6
      row(7, 1,6, 0, 0,0,1,0, 1,'h180,1),  // R7 return forces system stack, R6
      row(6, 1,0, 1, 0,0,1,0, 1,'h190,0),  // R6 consumed
      row(6, 1,2, 0, 0,0,0,0, 0,'h180,0),  // R6
      row(6, 1,7, 0, 0,0,1,0, 1,'h180,0),  // R6 context jump writes
      row(6, 1,0, 0, 0,0,1,0, 1,'h180,0),  // R6 consumed
      row(8, 1,1, 0, 0,0,0,0, 0,'h180,0),  // R8
      row(9, 1,2, 0, 0,0,0,0, 0,'h180,0),  // R9 both pending
      row(8, 0,3, 5, 0,1,1,0, 0,'h1D0,0),  // R8 interrupt entry, R11 idle
      row(8, 1,0, 5, 2,0,1,0, 1,'h1D2,0),  // R8 both cleared
      row(9, 1,1,12, 0,0,0,0, 0,'h240,0),  // R9
      row(9, 1,2,12, 0,0,0,0, 0,'h240,0),  // R9
      row(9, 1,0,12, 4,0,1,0, 0,'h184,0),  // R9 both apply
      row(10,1,0,12, 4,0,1,0, 1,'h244,0),  // R10 both consumed
      row(11,1,2, 0, 0,0,1,0, 0,'h180,0),  // R11 prefix strobe no write
      row(11,0,0, 3, 0,0,1,0, 0,'h1B0,0),  // R11 idle no write, R3 held
      row(3, 1,0, 3, 0,0,1,0, 0,'h1B0,0)   // R3 still pending after idle
   };

   task automatic drive(input logic v, input logic [2:0] c, input logic [4:0] p,
                        input logic [3:0] i, input logic q, input logic r, input logic s);
      dec_valid = v; dec_class = c; bank_ptr = p; reg_idx = i;
      irq_entry = q; ccr_req = r; stack_flag = s;
   endtask

   task automatic check(input int tag, input logic we, input logic [23:0] a, input logic sy);
      checks++;
      if (ccr_we !== we || reg_addr !== a || sys_stack !== sy) begin
         errors++;
         $display("FAIL R%0d: got we=%0b addr=%h sys=%0b, expected we=%0b addr=%h sys=%0b",
                  tag, ccr_we, reg_addr, sys_stack, we, a, sy);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11 reset state: plain instruction sees no prefix
      @(negedge clk);
      drive(1, 3'd0, 5'd1, 4'd1, 0, 1, 0);
      #2 check(11, 1'b1, 24'h191, 1'b0);

      for (int k = 0; k < NV; k++) begin
         @(negedge clk);
         drive(VEC[k][41], VEC[k][40:38], VEC[k][37:33], VEC[k][32:29],
               VEC[k][28], VEC[k][27], VEC[k][26]);
         #2 check(int'(VEC[k][45:42]), VEC[k][25], VEC[k][24:1], VEC[k][0]);
      end

      // R11 reset clears both pending prefixes
      @(negedge clk); drive(1, 3'd1, 5'd0, 4'd0, 0, 0, 0);
      @(negedge clk); drive(1, 3'd2, 5'd0, 4'd0, 0, 0, 0);
      @(negedge clk); drive(0, 3'd0, 5'd0, 4'd0, 0, 0, 0); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk); drive(1, 3'd0, 5'd2, 4'd0, 0, 1, 0);
      #2 check(11, 1'b1, 24'h1A0, 1'b0);

      // R8 interrupt entry in the same cycle as a prefix strobe wins
      @(negedge clk); drive(1, 3'd2, 5'd0, 4'd0, 1, 0, 0);
      @(negedge clk); drive(1, 3'd0, 5'd6, 4'd7, 0, 1, 0);
      #2 check(8, 1'b1, 24'h1E7, 1'b0);

      // R1 non-zero index on bank pointer 1
      @(negedge clk); drive(1, 3'd3, 5'd1, 4'd9, 0, 0, 0);
      #2 check(1, 1'b0, 24'h199, 1'b0);

      @(negedge clk);
      drive(0, 3'd0, 5'd0, 4'd0, 0, 0, 0);
      @(negedge clk);
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      finish_run();
   end

endmodule